// File: doc/BRIEF.md
# Four-Channel Double-Buffered Converter Register File

This block holds the digital side of four output converter channels, numbered 0 to 3 (channel 0 is the first channel, channel 3 the last). Software reaches it over a 16-bit register bus. Each channel has a staged data word and an active data word. A shared control word carries one polarity bit and one gain bit per channel, and it is also kept as a staged copy and an active copy. Staged values move into the active registers when software reads one of two commit locations. These reads carry no data back. They act only as strobes.

A mode register holds two bits. One enables the converters. While the enable is low, every code output sits at midscale. The other bit selects double-buffered operation. With it off, a data write goes straight through to its channel. With it on, data writes only fill the staging words, and a single commit read then moves all four channels in the same cycle. That lets several channels change together. All outputs are registered. Every bus access shows on the outputs one clock after the edge that samples it.

Top module: `dac_shadow_regs`

## Requirements
- R1: A synchronous active-high reset clears every staged and active register to zero. It drives every code output to midscale (2^(DW-1)), and drives enable, buffered mode, polarity and gain outputs low. After a later enable with no data writes, every code reads 0.
- R2: A write to byte address 0x02 loads the mode register. Bit 1 is the converter enable and bit 0 is buffered mode. The two bits appear on `dac_en` and `dac_buffered`.
- R3: In buffered mode, a write to a channel's data address (0x14 + 2*channel) leaves every code output unchanged.
- R4: A read of byte address 0x02 copies all four staged data words into the active registers in the same cycle.
- R5: With buffered mode off, a data write updates only the addressed channel's active word and output. The other channels keep their values.
- R6: A write to byte address 0x12 only stages the control word. The polarity and gain outputs change only after a read of address 0x12 commits it.
- R7: In the control word, the polarity bit of channel i is bit 7-i and its gain bit is bit 11-i. These appear on `dac_bipolar[i]` and `dac_gain[i]`.
- R8: While the enable is low, every code output is midscale. The active words are kept, and they reappear once the enable is set again.
- R9: Each bus access changes the outputs exactly one clock after the edge that samples it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 16 | Write data |
| dac_code | output | NCH*DW | Code of channel i in bits [i*DW +: DW] |
| dac_bipolar | output | NCH | Per-channel polarity, active control |
| dac_gain | output | NCH | Per-channel gain, active control |
| dac_en | output | 1 | Converter enable |
| dac_buffered | output | 1 | Buffered mode indication |

## Verification
The hardest case to reach is a buffered commit, which has to prove that all four channels move in one cycle. The bench sets buffered mode and writes a distinct word to each channel while one channel already holds an older value. It then checks that nothing moved before issuing the commit read. After the commit it checks all four outputs on the same sample. The midscale override is reached by clearing the enable after active words have been loaded. A staged commit is then done while disabled, which shows that the hidden active values survive and update.

// File: rtl/dac_regs_pkg.sv
package dac_regs_pkg;
  // byte offsets on the register bus
  localparam int unsigned MODE_OFS  = 'h02;  // write: mode, read: data commit
  localparam int unsigned CTL_OFS   = 'h12;  // write: staged control, read: control commit
  localparam int unsigned DATA0_OFS = 'h14;  // channel i data at DATA0_OFS + 2*i
  // bit positions inside the written words
  localparam int unsigned EN_BIT    = 1;
  localparam int unsigned BUF_BIT   = 0;
  localparam int unsigned POL_TOP   = 7;     // channel i polarity: POL_TOP - i
  localparam int unsigned GAIN_TOP  = 11;    // channel i gain: GAIN_TOP - i
  localparam int unsigned BUS_W     = 16;

  typedef struct packed {
    logic en;
    logic buffered;
  } mode_t;
endpackage

// File: rtl/dac_bus_decode.sv
module dac_bus_decode
  import dac_regs_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic              mode_we,
  output logic              ctl_we,
  output logic              data_commit,
  output logic              ctl_commit,
  output logic [NCH-1:0]    data_we
);
  assign mode_we     = bus_wr && (bus_addr == ADDR_W'(MODE_OFS));
  assign ctl_we      = bus_wr && (bus_addr == ADDR_W'(CTL_OFS));
  assign data_commit = bus_rd && (bus_addr == ADDR_W'(MODE_OFS));
  assign ctl_commit  = bus_rd && (bus_addr == ADDR_W'(CTL_OFS));

  for (genvar i = 0; i < NCH; i++) begin : g_dec
    assign data_we[i] = bus_wr && (bus_addr == ADDR_W'(DATA0_OFS + 2 * i));
  end
endmodule

// File: rtl/dac_ctrl_regs.sv
module dac_ctrl_regs
  import dac_regs_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           mode_we,
  input  logic           ctl_we,
  input  logic           ctl_commit,
  input  mode_t          mode_wdata,
  input  logic [NCH-1:0] pol_wdata,   // already in channel order
  input  logic [NCH-1:0] gain_wdata,  // already in channel order
  output mode_t          mode_q,      // internal, feeds the channels
  output logic           en_o,
  output logic           buffered_o,
  output logic [NCH-1:0] pol_o,
  output logic [NCH-1:0] gain_o
);
  logic [NCH-1:0] pol_stage, gain_stage, pol_act, gain_act;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q     <= '0;
      pol_stage  <= '0;
      gain_stage <= '0;
      pol_act    <= '0;
      gain_act   <= '0;
    end else begin
      if (mode_we) mode_q <= mode_wdata;
      if (ctl_we) begin
        pol_stage  <= pol_wdata;
        gain_stage <= gain_wdata;
      end
      if (ctl_commit) begin
        pol_act  <= pol_stage;
        gain_act <= gain_stage;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_o       <= 1'b0;
      buffered_o <= 1'b0;
      pol_o      <= '0;
      gain_o     <= '0;
    end else begin
      en_o       <= mode_q.en;
      buffered_o <= mode_q.buffered;
      pol_o      <= pol_act;
      gain_o     <= gain_act;
    end
  end
endmodule

// File: rtl/dac_channel.sv
module dac_channel #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          stage_we,
  input  logic          commit,
  input  logic          direct,
  input  logic          enable,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] code_o
);
  localparam logic [DW-1:0] MID = {1'b1, {(DW-1){1'b0}}};

  logic [DW-1:0] staged, active;

  always_ff @(posedge clk) begin
    if (rst) begin
      staged <= '0;
      active <= '0;
    end else begin
      if (stage_we) staged <= wdata;
      if (commit)                  active <= staged;
      else if (stage_we && direct) active <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) code_o <= MID;
    else     code_o <= enable ? active : MID;
  end
endmodule

// File: rtl/dac_shadow_regs.sv
module dac_shadow_regs
  import dac_regs_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int DW     = 16,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [15:0]       bus_wdata,
  output logic [NCH*DW-1:0] dac_code,
  output logic [NCH-1:0]    dac_bipolar,
  output logic [NCH-1:0]    dac_gain,
  output logic              dac_en,
  output logic              dac_buffered
);
  logic           mode_we, ctl_we, data_commit, ctl_commit;
  logic [NCH-1:0] data_we;
  logic [NCH-1:0] pol_wdata, gain_wdata;
  mode_t          mode_wdata, mode_q;

  dac_bus_decode #(.NCH(NCH), .ADDR_W(ADDR_W)) u_dec (
    .bus_addr    (bus_addr),
    .bus_wr      (bus_wr),
    .bus_rd      (bus_rd),
    .mode_we     (mode_we),
    .ctl_we      (ctl_we),
    .data_commit (data_commit),
    .ctl_commit  (ctl_commit),
    .data_we     (data_we)
  );

  assign mode_wdata.en       = bus_wdata[EN_BIT];
  assign mode_wdata.buffered = bus_wdata[BUF_BIT];

  // control fields run downward from the first channel
  for (genvar i = 0; i < NCH; i++) begin : g_fld
    assign pol_wdata[i]  = bus_wdata[POL_TOP - i];
    assign gain_wdata[i] = bus_wdata[GAIN_TOP - i];
  end

  dac_ctrl_regs #(.NCH(NCH)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .mode_we    (mode_we),
    .ctl_we     (ctl_we),
    .ctl_commit (ctl_commit),
    .mode_wdata (mode_wdata),
    .pol_wdata  (pol_wdata),
    .gain_wdata (gain_wdata),
    .mode_q     (mode_q),
    .en_o       (dac_en),
    .buffered_o (dac_buffered),
    .pol_o      (dac_bipolar),
    .gain_o     (dac_gain)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    dac_channel #(.DW(DW)) u_ch (
      .clk      (clk),
      .rst      (rst),
      .stage_we (data_we[i]),
      .commit   (data_commit),
      .direct   (!mode_q.buffered),
      .enable   (mode_q.en),
      .wdata    (bus_wdata[DW-1:0]),
      .code_o   (dac_code[i*DW +: DW])
    );
  end
endmodule

// File: rtl/dac_shadow_regs_chk.sv
module dac_shadow_regs_chk
  import dac_regs_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int DW     = 16,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [NCH*DW-1:0] dac_code,
  input logic [NCH-1:0]    dac_bipolar,
  input logic [NCH-1:0]    dac_gain,
  input logic              dac_en
);
  localparam logic [DW-1:0] MID = {1'b1, {(DW-1){1'b0}}};

  AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (dac_code == {NCH{MID}} && !dac_en && dac_bipolar == '0 && dac_gain == '0)); // R1

  AST_DISABLED_MID: assert property (@(posedge clk) disable iff (rst)
    !dac_en |-> dac_code == {NCH{MID}}); // R8

  AST_CTL_NEEDS_COMMIT: assert property (@(posedge clk) disable iff (rst)
    !($stable(dac_bipolar) && $stable(dac_gain)) |-> $past(bus_rd && bus_addr == ADDR_W'(CTL_OFS), 2)); // R6

  AST_EN_FROM_MODE_WRITE: assert property (@(posedge clk) disable iff (rst)
    !$stable(dac_en) |-> $past(bus_wr && bus_addr == ADDR_W'(MODE_OFS), 2)); // R2

  AST_CODE_NEEDS_ACCESS: assert property (@(posedge clk) disable iff (rst)
    !$stable(dac_code) |-> $past(bus_wr || bus_rd, 2)); // R9
endmodule

bind dac_shadow_regs dac_shadow_regs_chk #(.NCH(NCH), .DW(DW), .ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .bus_addr    (bus_addr),
  .bus_wr      (bus_wr),
  .bus_rd      (bus_rd),
  .dac_code    (dac_code),
  .dac_bipolar (dac_bipolar),
  .dac_gain    (dac_gain),
  .dac_en      (dac_en)
);

// File: tb/dac_shadow_regs_bench.sv
`timescale 1ns/1ps
module dac_shadow_regs_bench;
  localparam int NCH = 4;
  localparam int DW  = 16;
  localparam int AW  = 8;
  localparam logic [DW-1:0] MID = 16'h8000;

  logic          clk = 0;
  logic          rst = 1;
  logic [AW-1:0] bus_addr = '0;
  logic          bus_wr = 0, bus_rd = 0;
  logic [15:0]   bus_wdata = '0;
  logic [NCH*DW-1:0] dac_code;
  logic [NCH-1:0]    dac_bipolar, dac_gain;
  logic              dac_en, dac_buffered;

  int errors = 0, checks = 0;
  bit done = 0;
  logic [DW-1:0] exp_code [NCH];

  always #10 clk = ~clk;

  dac_shadow_regs #(.NCH(NCH), .DW(DW), .ADDR_W(AW)) u_dac_shadow_regs (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .dac_code(dac_code), .dac_bipolar(dac_bipolar),
    .dac_gain(dac_gain), .dac_en(dac_en), .dac_buffered(dac_buffered)
  );

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_codes(string req);
    for (int i = 0; i < NCH; i++)
      check(req, 64'(dac_code[i*DW +: DW]), 64'(exp_code[i]));
  endtask

  // one bus cycle, then one more cycle for the output register
  task automatic bus_write(input logic [AW-1:0] a, input logic [15:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
    @(negedge clk);
  endtask

  task automatic bus_read(input logic [AW-1:0] a);
    @(negedge clk); bus_addr = a; bus_rd = 1;
    @(negedge clk); bus_rd = 0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    for (int i = 0; i < NCH; i++) exp_code[i] = MID;
    check_codes("R1 reset midscale");
    check("R1 reset en", 64'(dac_en), 0);
    check("R1 reset buffered", 64'(dac_buffered), 0);
    check("R1 reset polarity", 64'(dac_bipolar), 0);
    check("R1 reset gain", 64'(dac_gain), 0);
  endtask

  task automatic t_enable();
    bus_write(8'h02, 16'h0002);
    check("R2 enable", 64'(dac_en), 1);
    check("R2 buffered off", 64'(dac_buffered), 0);
    for (int i = 0; i < NCH; i++) exp_code[i] = '0;
    check_codes("R1 active cleared");
  endtask

  task automatic t_direct();
    bus_write(8'h16, 16'h1234);
    exp_code[1] = 16'h1234;
    check_codes("R5 direct write channel 1");
    // R9: exactly one cycle after the sampling edge
    @(negedge clk); bus_addr = 8'h1A; bus_wdata = 16'hBEEF; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
    check("R9 not yet", 64'(dac_code[3*DW +: DW]), 64'(16'h0000));
    @(negedge clk);
    exp_code[3] = 16'hBEEF;
    check("R9 one cycle later", 64'(dac_code[3*DW +: DW]), 64'(16'hBEEF));
  endtask

  task automatic t_buffered();
    bus_write(8'h02, 16'h0003);
    check("R2 buffered on", 64'(dac_buffered), 1);
    for (int i = 0; i < NCH; i++) bus_write(8'(8'h14 + 2 * i), 16'(16'hA000 + 16'h0111 * i));
    check_codes("R3 buffered writes hidden");
    bus_read(8'h02);
    for (int i = 0; i < NCH; i++) exp_code[i] = 16'(16'hA000 + 16'h0111 * i);
    check_codes("R4 commit all channels");
  endtask

  task automatic t_ctrl();
    bus_write(8'h12, 16'h0380);
    check("R6 staged polarity hidden", 64'(dac_bipolar), 0);
    check("R6 staged gain hidden", 64'(dac_gain), 0);
    bus_read(8'h12);
    check("R7 polarity map", 64'(dac_bipolar), 64'(4'b0001));
    check("R7 gain map", 64'(dac_gain), 64'(4'b1100));
    bus_write(8'h12, 16'h0C50);
    bus_read(8'h12);
    check("R7 polarity map 2", 64'(dac_bipolar), 64'(4'b1010));
    check("R7 gain map 2", 64'(dac_gain), 64'(4'b0011));
  endtask

  task automatic t_disable();
    bus_write(8'h02, 16'h0001);
    check("R8 disabled", 64'(dac_en), 0);
    for (int i = 0; i < NCH; i++)
      check("R8 midscale", 64'(dac_code[i*DW +: DW]), 64'(MID));
    bus_write(8'h14, 16'h7777);
    bus_read(8'h02);
    check("R8 still midscale", 64'(dac_code[0 +: DW]), 64'(MID));
    bus_write(8'h02, 16'h0002);
    exp_code[0] = 16'h7777;
    check_codes("R8 active restored");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_enable();
    t_direct();
    t_buffered();
    t_ctrl();
    t_disable();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule